// File: doc/BRIEF.md
# Keyed Non-Volatile Memory Operation Controller

This block is the register front end that stands between a processor bus and a non-volatile memory array. Software uses a small set of 32-bit registers to choose an operation, a target address and a data word. The block then starts that operation on the array and reports when it is finished and whether it failed. A program or erase can only begin after an unlock ritual. Software must first set a write-enable bit. It then writes two fixed key words to the key register, in order, as consecutive bus writes. The very next bus write must request the start bit. Any other sequence leaves the array untouched.

The control word and the address register can be written directly or through clear, set and toggle aliases, so single bits can be changed without a read-modify-write. While an operation runs, the start/busy bit reads 1 and the operation parameters are frozen. When the array reports completion, the busy bit drops and two sticky error flags capture the array's fault and low-voltage outcomes.

Two state machines drive the block. The unlock tracker has the states `UL_IDLE`, `UL_HALF` and `UL_ARMED`:
- The first key moves it to `UL_HALF`.
- The second key written right after it moves it to `UL_ARMED`.
- Any other bus write returns it to `UL_IDLE`. The exception is a first-key write, which goes to `UL_HALF` again.

The operation sequencer has the states `SQ_IDLE`, `SQ_LAUNCH` and `SQ_WAIT`:
- An accepted start moves it from `SQ_IDLE` to `SQ_LAUNCH`. That state lasts one cycle and raises the start pulse.
- It always moves on to `SQ_WAIT`.
- An array done indication returns it to `SQ_IDLE`.

Top module: `keyed_nvm_ctrl`

## Requirements
- R1: After reset, every readable register reads 0 and `arr_start` is low.
- R2: Control register, byte offset 0x00. Bit 15 is start/busy, bit 14 is write-enable, bit 13 is the array-fault flag, bit 12 is the low-voltage fault flag, bit 11 is low-voltage status and bits 3:0 are the operation code (0 none, 1 word program, 3 row program, 4 page erase, 5 whole-array erase). A write at 0x00 replaces bit 14 and bits 3:0. Writes at 0x04, 0x08 and 0x0C clear, set or toggle only those of these bits that are written as 1.
- R3: The target address register reads at 0x20. Writes at 0x20, 0x24, 0x28 and 0x2C replace, clear, set or toggle its bits written as 1. The data register is at 0x30 and a source-address register is at 0x40.
- R4: A start is accepted when three things hold. Write-enable is already 1. The two previous bus writes were 0xAA996655 and then 0x556699AA to the key register at 0x10. The current write to a control offset drives bit 15 to 1. On acceptance, bit 15 reads 1 from the next cycle. `arr_start` is high for exactly the one cycle after the accepting write edge, while `arr_op`, `arr_addr` and `arr_data` show the register values.
- R5: A start request is ignored when write-enable is 0, when a key is wrong, when the keys come in the wrong order, or when any other bus write falls between the keys.
- R6: One key pair allows at most one start. A later start request without a new key pair is ignored.
- R7: Bit 15 reads 0 from the cycle after `arr_done` is sampled in `SQ_WAIT`. `arr_done` in `SQ_IDLE` or `SQ_LAUNCH` has no effect.
- R8: While busy, writes to the operation code, the address register and the data register are ignored, and write-enable cannot be cleared.
- R9: At completion, bit 13 takes `arr_err` and bit 12 takes `arr_lv_err`. Both flags then hold, software writes do not change them, and they clear when the next start is accepted.
- R10: Bit 11 shows the live level of `arr_lv_stat`.
- R11: `bus_rdata` is 0 when `bus_rd` is low. It is also 0 for the key register, the alias offsets and unmapped or unaligned offsets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| arr_start | output | 1 | One-cycle operation start toward the array |
| arr_op | output | 4 | Operation code toward the array |
| arr_addr | output | 32 | Target address toward the array |
| arr_data | output | 32 | Data word toward the array |
| arr_done | input | 1 | Array finished the running operation |
| arr_err | input | 1 | Array fault outcome, valid with `arr_done` |
| arr_lv_err | input | 1 | Low-voltage fault outcome, valid with `arr_done` |
| arr_lv_stat | input | 1 | Live low-voltage status |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the start pulse lasts one cycle;
- a rise of busy always coincides with a consumed unlock and cleared error flags;
- busy only falls after a done indication;
- operation parameters and write-enable stay frozen while busy.

Other behaviours can only be shown by the bench's scenarios, where a behavioural model is compared against the array outputs every clock. These are:
- the key-sequence rejections (wrong value, wrong order, interposed write, enable clear);
- the alias arithmetic on both aliased registers;
- the done pulses that arrive outside `SQ_WAIT`;
- the sticky capture of each error outcome.

// File: rtl/nvmk_pkg.sv
package nvmk_pkg;

    localparam int NVMK_DW  = 32;
    localparam int NVMK_AW  = 8;
    localparam int NVMK_OPW = 4;

    // Register block codes: byte offset bits [7:4]
    localparam logic [3:0] BLK_CTRL = 4'h0;
    localparam logic [3:0] BLK_KEY  = 4'h1;
    localparam logic [3:0] BLK_ADDR = 4'h2;
    localparam logic [3:0] BLK_DATA = 4'h3;
    localparam logic [3:0] BLK_SRC  = 4'h4;

    // Control word bit positions
    localparam int BIT_GO     = 15;
    localparam int BIT_WREN   = 14;
    localparam int BIT_FAULT  = 13;
    localparam int BIT_LVFLT  = 12;
    localparam int BIT_LVSTAT = 11;

    localparam logic [31:0] UNLOCK_FIRST  = 32'hAA99_6655;
    localparam logic [31:0] UNLOCK_SECOND = 32'h5566_99AA;

    // Alias kind: byte offset bits [3:2]
    typedef enum logic [1:0] {
        ALIAS_PUT = 2'd0,
        ALIAS_CLR = 2'd1,
        ALIAS_SET = 2'd2,
        ALIAS_INV = 2'd3
    } alias_e;

    typedef enum logic [1:0] {
        UL_IDLE  = 2'd0,
        UL_HALF  = 2'd1,
        UL_ARMED = 2'd2
    } unlock_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_LAUNCH = 2'd1,
        SQ_WAIT   = 2'd2
    } seq_e;

endpackage

// File: rtl/nvmk_alias_mix.sv
module nvmk_alias_mix
    import nvmk_pkg::*;
#(
    parameter int W = 32
) (
    input  alias_e         kind_i,
    input  logic [W-1:0]   cur_i,
    input  logic [W-1:0]   wdata_i,
    output logic [W-1:0]   nxt_o
);

    always_comb begin
        unique case (kind_i)
            ALIAS_PUT: nxt_o = wdata_i;
            ALIAS_CLR: nxt_o = cur_i & ~wdata_i;
            ALIAS_SET: nxt_o = cur_i | wdata_i;
            ALIAS_INV: nxt_o = cur_i ^ wdata_i;
            default:   nxt_o = cur_i;
        endcase
    end

endmodule

// File: rtl/nvmk_unlock.sv
module nvmk_unlock
    import nvmk_pkg::*;
#(
    parameter int          DW     = 32,
    parameter logic [31:0] KEY_A  = UNLOCK_FIRST,
    parameter logic [31:0] KEY_B  = UNLOCK_SECOND
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic          key_sel_i,
    input  logic [DW-1:0] wdata_i,
    output logic          armed_o
);

    unlock_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= UL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            if (key_sel_i && (wdata_i == DW'(KEY_A))) begin
                state_d = UL_HALF;
            end else if ((state_q == UL_HALF) && key_sel_i &&
                         (wdata_i == DW'(KEY_B))) begin
                state_d = UL_ARMED;
            end else begin
                state_d = UL_IDLE;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            UL_ARMED: armed_o = 1'b1;
            default:  armed_o = 1'b0;
        endcase
    end

    AST_ARMED_AFTER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_o) |-> $past(state_q == UL_HALF)) else $error("armed skipped half"); // R5

endmodule

// File: rtl/nvmk_seq.sv
module nvmk_seq
    import nvmk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic done_i,
    input  logic fail_i,
    input  logic lowv_i,
    output logic busy_o,
    output logic start_o,
    output logic fail_o,
    output logic lowv_o
);

    seq_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:   if (go_i) state_d = SQ_LAUNCH;
            SQ_LAUNCH: state_d = SQ_WAIT;
            SQ_WAIT:   if (done_i) state_d = SQ_IDLE;
            default:   state_d = SQ_IDLE;
        endcase
    end

    always_comb begin
        busy_o  = 1'b1;
        start_o = 1'b0;
        unique case (state_q)
            SQ_IDLE:   busy_o = 1'b0;
            SQ_LAUNCH: start_o = 1'b1;
            SQ_WAIT:   busy_o = 1'b1;
            default:   busy_o = 1'b0;
        endcase
    end

    // Sticky outcome flags: cleared by an accepted start, loaded at completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_o <= 1'b0;
            lowv_o <= 1'b0;
        end else if ((state_q == SQ_IDLE) && go_i) begin
            fail_o <= 1'b0;
            lowv_o <= 1'b0;
        end else if ((state_q == SQ_WAIT) && done_i) begin
            fail_o <= fail_i;
            lowv_o <= lowv_i;
        end
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o) else $error("start pulse too long"); // R4

    AST_BUSY_DROP_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_i)) else $error("busy fell without done"); // R7

endmodule

// File: rtl/keyed_nvm_ctrl.sv
module keyed_nvm_ctrl
    import nvmk_pkg::*;
#(
    parameter int DW  = NVMK_DW,
    parameter int AW  = NVMK_AW,
    parameter int OPW = NVMK_OPW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           arr_start,
    output logic [OPW-1:0] arr_op,
    output logic [DW-1:0]  arr_addr,
    output logic [DW-1:0]  arr_data,
    input  logic           arr_done,
    input  logic           arr_err,
    input  logic           arr_lv_err,
    input  logic           arr_lv_stat
);

    localparam int BLKW = AW - 4;
    localparam int CW   = OPW + 2;   // {go, wren, op}

    logic [BLKW-1:0] blk;
    alias_e          kind;
    logic            aligned;
    logic            ctrl_sel, key_sel, addr_sel, data_sel, src_sel;

    logic            busy, seq_fail, seq_lowv, armed, go;
    logic            wren_q;
    logic [OPW-1:0]  op_q;
    logic [DW-1:0]   addr_q, data_q, src_q;
    logic [CW-1:0]   ctrl_cur, ctrl_wv, ctrl_nxt;
    logic [DW-1:0]   addr_nxt;
    logic [DW-1:0]   ctrl_view;

    // ---------------- decode ----------------
    assign blk     = bus_addr[AW-1:4];
    assign kind    = alias_e'(bus_addr[3:2]);
    assign aligned = (bus_addr[1:0] == 2'b00);

    assign ctrl_sel = bus_wr && aligned && (blk == BLKW'(BLK_CTRL));
    assign addr_sel = bus_wr && aligned && (blk == BLKW'(BLK_ADDR));
    assign key_sel  = bus_wr && aligned && (blk == BLKW'(BLK_KEY))  && (kind == ALIAS_PUT);
    assign data_sel = bus_wr && aligned && (blk == BLKW'(BLK_DATA)) && (kind == ALIAS_PUT);
    assign src_sel  = bus_wr && aligned && (blk == BLKW'(BLK_SRC))  && (kind == ALIAS_PUT);

    // ---------------- alias arithmetic ----------------
    assign ctrl_cur = {busy, wren_q, op_q};
    assign ctrl_wv  = {bus_wdata[BIT_GO], bus_wdata[BIT_WREN], bus_wdata[OPW-1:0]};

    nvmk_alias_mix #(.W(CW)) i_ctrl_mix (
        .kind_i  (kind),
        .cur_i   (ctrl_cur),
        .wdata_i (ctrl_wv),
        .nxt_o   (ctrl_nxt)
    );

    nvmk_alias_mix #(.W(DW)) i_addr_mix (
        .kind_i  (kind),
        .cur_i   (addr_q),
        .wdata_i (bus_wdata),
        .nxt_o   (addr_nxt)
    );

    // ---------------- unlock and sequencing ----------------
    nvmk_unlock #(.DW(DW)) i_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (bus_wr),
        .key_sel_i (key_sel),
        .wdata_i   (bus_wdata),
        .armed_o   (armed)
    );

    assign go = ctrl_sel && ctrl_nxt[CW-1] && !busy && armed && wren_q;

    nvmk_seq i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (go),
        .done_i  (arr_done),
        .fail_i  (arr_err),
        .lowv_i  (arr_lv_err),
        .busy_o  (busy),
        .start_o (arr_start),
        .fail_o  (seq_fail),
        .lowv_o  (seq_lowv)
    );

    // ---------------- registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wren_q <= 1'b0;
            op_q   <= '0;
        end else if (ctrl_sel) begin
            if (busy) begin
                wren_q <= wren_q | ctrl_nxt[OPW];
            end else begin
                wren_q <= ctrl_nxt[OPW];
                op_q   <= ctrl_nxt[OPW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            src_q  <= '0;
        end else begin
            if (addr_sel && !busy) addr_q <= addr_nxt;
            if (data_sel && !busy) data_q <= bus_wdata;
            if (src_sel)           src_q  <= bus_wdata;
        end
    end

    assign arr_op   = op_q;
    assign arr_addr = addr_q;
    assign arr_data = data_q;

    // ---------------- read path ----------------
    always_comb begin
        ctrl_view             = '0;
        ctrl_view[BIT_GO]     = busy;
        ctrl_view[BIT_WREN]   = wren_q;
        ctrl_view[BIT_FAULT]  = seq_fail;
        ctrl_view[BIT_LVFLT]  = seq_lowv;
        ctrl_view[BIT_LVSTAT] = arr_lv_stat;
        ctrl_view[OPW-1:0]    = op_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && aligned && (kind == ALIAS_PUT)) begin
            case (blk)
                BLKW'(BLK_CTRL): bus_rdata = ctrl_view;
                BLKW'(BLK_ADDR): bus_rdata = addr_q;
                BLKW'(BLK_DATA): bus_rdata = data_q;
                BLKW'(BLK_SRC):  bus_rdata = src_q;
                default:         bus_rdata = '0;
            endcase
        end
    end

    // ---------------- assertions ----------------
    AST_START_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(armed) && $past(wren_q)) else $error("start without unlock"); // R4

    AST_UNLOCK_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !armed) else $error("unlock survived start"); // R6

    AST_FROZEN_PARAMS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> $stable(arr_op) && $stable(arr_addr) && $stable(arr_data)) else $error("params changed while busy"); // R8

    AST_WREN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) && $past(wren_q) |-> wren_q) else $error("enable dropped while busy"); // R8

    AST_FLAGS_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !seq_fail && !seq_lowv) else $error("flags not cleared"); // R9

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0)) else $error("read data without strobe"); // R11

endmodule

// File: tb/test_keyed_nvm_ctrl.sv
module test_keyed_nvm_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        arr_start;
    logic [3:0]  arr_op;
    logic [31:0] arr_addr, arr_data;
    logic        arr_done = 1'b0, arr_err = 1'b0, arr_lv_err = 1'b0, arr_lv_stat = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    localparam logic [31:0] K1 = 32'hAA99_6655;
    localparam logic [31:0] K2 = 32'h5566_99AA;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_nvm_ctrl i_keyed_nvm_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .arr_start(arr_start), .arr_op(arr_op), .arr_addr(arr_addr), .arr_data(arr_data),
        .arr_done(arr_done), .arr_err(arr_err), .arr_lv_err(arr_lv_err),
        .arr_lv_stat(arr_lv_stat)
    );

    // ---------------- behavioural reference model ----------------
    int          m_phase;   // 0 idle, 1 start cycle, 2 waiting
    int          m_key;     // 0 none, 1 first key seen, 2 pair complete
    logic        m_wren;
    logic [3:0]  m_op;
    logic [31:0] m_addr, m_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_key = 0; m_wren = 0; m_op = 0; m_addr = 0; m_data = 0;
        end else begin
            bit busy_now, go, ng, nw;
            logic [3:0] no;
            busy_now = (m_phase != 0);
            go = 0; ng = 0; nw = 0; no = 0;
            if (bus_wr) begin
                if (bus_addr == 8'h00 || bus_addr == 8'h04 || bus_addr == 8'h08 || bus_addr == 8'h0C) begin
                    case (bus_addr)
                        8'h00: begin ng = bus_wdata[15]; nw = bus_wdata[14]; no = bus_wdata[3:0]; end
                        8'h04: begin ng = busy_now & ~bus_wdata[15]; nw = m_wren & ~bus_wdata[14]; no = m_op & ~bus_wdata[3:0]; end
                        8'h08: begin ng = busy_now | bus_wdata[15]; nw = m_wren | bus_wdata[14]; no = m_op | bus_wdata[3:0]; end
                        default: begin ng = busy_now ^ bus_wdata[15]; nw = m_wren ^ bus_wdata[14]; no = m_op ^ bus_wdata[3:0]; end
                    endcase
                    if (ng && !busy_now && m_key == 2 && m_wren) go = 1;
                    if (busy_now) m_wren = m_wren | nw;
                    else begin m_wren = nw; m_op = no; end
                end
                if (!busy_now) begin
                    case (bus_addr)
                        8'h20: m_addr = bus_wdata;
                        8'h24: m_addr = m_addr & ~bus_wdata;
                        8'h28: m_addr = m_addr | bus_wdata;
                        8'h2C: m_addr = m_addr ^ bus_wdata;
                        8'h30: m_data = bus_wdata;
                        default: ;
                    endcase
                end
                if (bus_addr == 8'h10 && bus_wdata == K1) m_key = 1;
                else if (m_key == 1 && bus_addr == 8'h10 && bus_wdata == K2) m_key = 2;
                else m_key = 0;
            end
            if (m_phase == 1) m_phase = 2;
            else if (m_phase == 2 && arr_done) m_phase = 0;
            if (go) m_phase = 1;
        end
    end

    // per-cycle comparison of array-side outputs (R4, R8)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (arr_start !== (m_phase == 1) || arr_op !== m_op ||
                arr_addr !== m_addr || arr_data !== m_data) begin
                errors++;
                $display("FAIL R4/R8 model compare: start=%0b op=%h addr=%h data=%h expected start=%0b op=%h addr=%h data=%h",
                         arr_start, arr_op, arr_addr, arr_data, (m_phase == 1), m_op, m_addr, m_data);
            end
        end
    end

    // ---------------- tasks ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s read 0x%h: actual %h expected %h", tag, a, bus_rdata, exp);
        end
        bus_rd = 0; bus_addr = 0;
    endtask

    task automatic chk_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic chk_word(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic done_pulse(input logic e, input logic lv);
        arr_done = 1; arr_err = e; arr_lv_err = lv;
        @(negedge clk);
        arr_done = 0; arr_err = 0; arr_lv_err = 0;
    endtask

    task automatic unlock_and_go(input logic [7:0] a);
        wr(8'h10, K1);
        wr(8'h10, K2);
        wr(a, 32'h0000_8000);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // ---------------- scenarios ----------------
    initial begin
        repeat (3) @(negedge clk);
        chk_bit(arr_start, 1'b0, "R1 start low in reset");
        rst_n = 1;
        chk_rd(8'h00, 32'h0, "R1 ctrl");
        chk_rd(8'h20, 32'h0, "R1 addr");
        chk_rd(8'h30, 32'h0, "R1 data");
        chk_rd(8'h40, 32'h0, "R1 src");

        // R2 control aliases
        wr(8'h00, 32'h0000_4003); chk_rd(8'h00, 32'h0000_4003, "R2 put");
        wr(8'h04, 32'h0000_4000); chk_rd(8'h00, 32'h0000_0003, "R2 clr");
        wr(8'h08, 32'h0000_4004); chk_rd(8'h00, 32'h0000_4007, "R2 set");
        wr(8'h0C, 32'h0000_0006); chk_rd(8'h00, 32'h0000_4001, "R2 inv");
        wr(8'h00, 32'hFFFF_3FF0); chk_rd(8'h00, 32'h0000_0000, "R9 flags not writable");

        // R3 address aliases and plain registers
        wr(8'h20, 32'h1D00_0000); chk_rd(8'h20, 32'h1D00_0000, "R3 put");
        wr(8'h28, 32'h0000_0F00); chk_rd(8'h20, 32'h1D00_0F00, "R3 set");
        wr(8'h24, 32'h1D00_0000); chk_rd(8'h20, 32'h0000_0F00, "R3 clr");
        wr(8'h2C, 32'h0000_0F0F); chk_rd(8'h20, 32'h0000_000F, "R3 inv");
        wr(8'h30, 32'hDEAD_BEEF); chk_rd(8'h30, 32'hDEAD_BEEF, "R3 data");
        wr(8'h40, 32'h1234_5678); chk_rd(8'h40, 32'h1234_5678, "R3 src");

        // R10 live status, R11 read gating
        arr_lv_stat = 1; chk_rd(8'h00, 32'h0000_0800, "R10 status high");
        arr_lv_stat = 0; chk_rd(8'h00, 32'h0000_0000, "R10 status low");
        @(negedge clk); bus_addr = 8'h30; #1;
        chk_word(bus_rdata, 32'h0, "R11 no strobe"); bus_addr = 0;
        chk_rd(8'h10, 32'h0, "R11 key reads zero");
        chk_rd(8'h50, 32'h0, "R11 unmapped");
        chk_rd(8'h32, 32'h0, "R11 unaligned");
        chk_rd(8'h28, 32'h0, "R11 alias reads zero");

        // R4 full operation
        wr(8'h00, 32'h0000_4001);
        wr(8'h20, 32'h1D00_0100);
        wr(8'h30, 32'hCAFE_F00D);
        unlock_and_go(8'h08);
        chk_bit(arr_start, 1'b1, "R4 start pulse");
        chk_word({28'h0, arr_op}, 32'h1, "R4 op out");
        chk_word(arr_addr, 32'h1D00_0100, "R4 addr out");
        chk_word(arr_data, 32'hCAFE_F00D, "R4 data out");
        @(negedge clk);
        chk_bit(arr_start, 1'b0, "R4 pulse one cycle");
        chk_rd(8'h00, 32'h0000_C001, "R4 busy reads 1");

        // R8 frozen while busy
        wr(8'h20, 32'h0000_0000);
        wr(8'h30, 32'h0000_0000);
        wr(8'h00, 32'h0000_0005);
        wr(8'h04, 32'h0000_4000);
        chk_rd(8'h00, 32'h0000_C001, "R8 op and enable held");
        chk_rd(8'h20, 32'h1D00_0100, "R8 addr held");
        chk_rd(8'h30, 32'hCAFE_F00D, "R8 data held");

        // R7/R9 completion with array fault
        done_pulse(1, 0);
        chk_rd(8'h00, 32'h0000_6001, "R7 R9 done with fault");
        repeat (3) @(negedge clk);
        chk_rd(8'h00, 32'h0000_6001, "R9 fault sticky");
        wr(8'h04, 32'h0000_4000);
        chk_rd(8'h00, 32'h0000_2001, "R9 enable clear keeps flag");

        // R6 unlock consumed
        wr(8'h00, 32'h0000_4001);
        wr(8'h08, 32'h0000_8000);
        chk_rd(8'h00, 32'h0000_6001, "R6 start without new keys");
        unlock_and_go(8'h08);
        chk_rd(8'h00, 32'h0000_C001, "R9 flags cleared at start");
        done_pulse(0, 1);
        chk_rd(8'h00, 32'h0000_5001, "R9 low-voltage fault");

        // R5 rejected sequences
        wr(8'h00, 32'h0000_4003);
        wr(8'h10, K1); wr(8'h10, 32'h1234_5678); wr(8'h10, K2); wr(8'h08, 32'h0000_8000);
        chk_rd(8'h00, 32'h0000_5003, "R5 wrong key");
        wr(8'h10, K1); wr(8'h30, 32'h0); wr(8'h10, K2); wr(8'h08, 32'h0000_8000);
        chk_rd(8'h00, 32'h0000_5003, "R5 interposed write");
        wr(8'h10, K2); wr(8'h10, K1); wr(8'h08, 32'h0000_8000);
        chk_rd(8'h00, 32'h0000_5003, "R5 wrong order");
        wr(8'h04, 32'h0000_4000);
        unlock_and_go(8'h08);
        chk_rd(8'h00, 32'h0000_1003, "R5 enable clear");

        // R4 start through toggle alias, done during start cycle ignored (R7)
        wr(8'h08, 32'h0000_4000);
        unlock_and_go(8'h0C);
        done_pulse(1, 1);
        chk_rd(8'h00, 32'h0000_C003, "R7 done in start cycle ignored");
        done_pulse(0, 0);
        chk_rd(8'h00, 32'h0000_4003, "R7 completion clean");

        // R7 done while idle
        @(negedge clk);
        done_pulse(1, 1);
        chk_rd(8'h00, 32'h0000_4003, "R7 done in idle ignored");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule